// File: doc/BRIEF.md
# Guarded Storage Access Gate

This block sits between a pipeline's memory-request stage and the memory port. Each cycle it may receive one access: a load, a store or an instruction fetch, together with a tag, an address, a size, a flag saying whether the access is still speculative, the guarded and caching-inhibited attributes of its page, and the result of a cache lookup. It decides in the same cycle whether the access goes out now, waits until it is no longer speculative, or is refused with an instruction storage fault.

Accesses to non-guarded storage and committed accesses to guarded storage go straight through. A speculative load to guarded storage also goes straight through when the cache already holds the line. Other speculative guarded accesses wait in a small in-order park queue. The oldest parked entry is released on a separate port when the pipeline's commit pointer names its tag. A flush discards everything that is parked. Every access that goes out carries its fetch size. When the page is caching-inhibited, the size covers only the requested bytes. Otherwise the address is aligned down to the cache block and the size covers the whole block.

Top module: `guarded_gate`

## Requirements
- R1: A valid request to non-guarded storage (req_guarded=0), of any kind, issues in the same cycle on the issue port, with iss_tag equal to req_tag and iss_kind equal to req_kind. Kind encoding: 2'b00 load, 2'b01 store, 2'b10 instruction fetch, 2'b11 treated as a store.
- R2: A guarded load or store with req_spec=0 issues in the same cycle.
- R3: A guarded load with req_spec=1 and req_hit=1 issues in the same cycle.
- R4: A guarded load with req_spec=1 and req_hit=0 does not issue. It is appended to the park queue, and stall is high from the next cycle.
- R5: A guarded store with req_spec=1 never issues directly, even when req_hit=1. It is parked like R4.
- R6: A guarded instruction fetch never issues and is never parked. fault_valid is high in the same cycle with fault_tag equal to req_tag, whatever req_spec is.
- R7: For caching-inhibited storage (req_inhibit=1), the address passes through unchanged, the exact flag is 1 and the byte count is 2^size. For cacheable storage, the address has its low log2(BLK_BYTES) bits cleared, the exact flag is 0 and the byte count is BLK_BYTES. This applies to both the issue port and the release port.
- R8: When commit_valid is high and commit_tag equals the tag of the oldest parked entry, that entry appears on the release port in the same cycle with its stored fields and is removed. A commit that names any other tag releases nothing. Entries leave in the order they were parked.
- R9: flush empties the park queue at the next edge and blocks any release in its own cycle. A request presented in the same cycle produces no issue, no fault and no park.
- R10: stall is high exactly when at least one entry is parked.
- R11: Reset (rst_n low, asynchronous) empties the park queue, so stall and park_full are low.
- R12: park_full is high when PARK_DEPTH entries are parked. A request that would park while park_full is high is discarded: no issue, no park, and the queue is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 store) |
| req_tag | input | TAG_W | Program-order tag of the request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SZ_W | log2 of the access size in bytes |
| req_spec | input | 1 | Request is still speculative |
| req_guarded | input | 1 | Page is guarded |
| req_inhibit | input | 1 | Page is caching-inhibited |
| req_hit | input | 1 | Cache lookup hit for the target line |
| commit_valid | input | 1 | Commit pointer update this cycle |
| commit_tag | input | TAG_W | Tag the commit pointer has reached |
| flush | input | 1 | Discard parked and incoming speculative work |
| iss_valid | output | 1 | Direct issue this cycle |
| iss_kind | output | 2 | Kind of the issued access |
| iss_tag | output | TAG_W | Tag of the issued access |
| iss_addr | output | ADDR_W | Issued address, exact or block-aligned |
| iss_bytes | output | BYTES_W | Bytes to fetch |
| iss_exact | output | 1 | 1 = exact location, 0 = whole cache block |
| fault_valid | output | 1 | Instruction storage fault this cycle |
| fault_tag | output | TAG_W | Tag of the faulting fetch |
| stall | output | 1 | At least one access is parked |
| park_full | output | 1 | Park queue holds PARK_DEPTH entries |
| rel_valid | output | 1 | Parked access released this cycle |
| rel_kind | output | 2 | Kind of the released access |
| rel_tag | output | TAG_W | Tag of the released access |
| rel_addr | output | ADDR_W | Released address, exact or block-aligned |
| rel_bytes | output | BYTES_W | Bytes to fetch for the release |
| rel_exact | output | 1 | 1 = exact location, 0 = whole cache block |

## Verification
The main decision is driven with every combination that separates the outcomes. Non-guarded requests of each kind show that the attributes do not delay them. Committed guarded requests separate the spec flag from the guarded flag. Speculative guarded loads with and without a hit, and speculative stores with a hit, separate the hit shortcut from the store rule. Guarded fetches, both speculative and committed, show that a fault does not depend on speculation. Commits that name a tag other than the oldest one, parks and releases in the same cycle, a queue filled past its depth, and a flush that coincides with both a request and a matching commit test the ordering and discard rules. Both attribute settings are applied on each port to tell exact-size from whole-block shaping.

// File: rtl/gate_pkg.sv
package gate_pkg;
   typedef enum logic [1:0] {
      K_LOAD  = 2'b00,
      K_STORE = 2'b01,
      K_FETCH = 2'b10,
      K_RSVD  = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      D_NONE  = 2'b00,
      D_PASS  = 2'b01,
      D_PARK  = 2'b10,
      D_FAULT = 2'b11
   } decision_e;
endpackage

// File: rtl/gate_classify.sv
module gate_classify
   import gate_pkg::*;
(
   input  logic       valid,
   input  logic       flush,
   input  logic       full,
   input  logic [1:0] kind,
   input  logic       spec,
   input  logic       guarded,
   input  logic       hit,
   output decision_e  dec
);
   acc_kind_e k;
   assign k = acc_kind_e'(kind);

   always_comb begin
      dec = D_NONE;
      if (valid && !flush) begin
         if (guarded && k == K_FETCH)
            dec = D_FAULT;
         else if (!guarded || !spec)
            dec = D_PASS;
         else if (k == K_LOAD && hit)
            dec = D_PASS;
         else if (!full)
            dec = D_PARK;
         else
            dec = D_NONE;
      end
   end
endmodule

// File: rtl/gate_shape.sv
module gate_shape #(
   parameter int ADDR_W   = 32,
   parameter int BLK_LOG2 = 6,
   parameter int SZ_W     = 3,
   parameter int BYTES_W  = 7
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [SZ_W-1:0]    size,
   input  logic               inhibit,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [BYTES_W-1:0] bytes_o,
   output logic               exact_o
);
   localparam logic [BYTES_W-1:0] BLK_BYTES_V = BYTES_W'(1) << BLK_LOG2;
   logic [ADDR_W-1:0] blk_addr;

   generate
      if (BLK_LOG2 == 0) begin : g_byte_block
         assign blk_addr = addr;
      end else begin : g_mask_block
         assign blk_addr = {addr[ADDR_W-1:BLK_LOG2], {BLK_LOG2{1'b0}}};
      end
   endgenerate

   assign exact_o = inhibit;
   assign addr_o  = inhibit ? addr : blk_addr;
   assign bytes_o = inhibit ? (BYTES_W'(1) << size) : BLK_BYTES_V;
endmodule

// File: rtl/gate_park_fifo.sv
module gate_park_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head_data,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH == 1) begin : g_single
         logic         held_q;
         logic [W-1:0] data_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held_q <= 1'b0;
            else if (flush)
               held_q <= 1'b0;
            else if (push)
               held_q <= 1'b1;
            else if (pop)
               held_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push && !flush)
               data_q <= push_data;
         end

         assign head_data = data_q;
         assign empty     = !held_q;
         assign full      = held_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);

         logic [PW-1:0] rd_q, wr_q;
         logic [CW-1:0] cnt_q;
         logic [W-1:0]  mem_q [DEPTH];

         function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
            end else if (flush) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wr_q <= step_ptr(wr_q);
               if (pop)  rd_q <= step_ptr(rd_q);
               case ({push, pop})
                  2'b10:   cnt_q <= cnt_q + CW'(1);
                  2'b01:   cnt_q <= cnt_q - CW'(1);
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push && !flush)
               mem_q[wr_q] <= push_data;
         end

         assign head_data = mem_q[rd_q];
         assign empty     = (cnt_q == '0);
         assign full      = (cnt_q == CW'(DEPTH));
      end
   endgenerate
endmodule

// File: rtl/guarded_gate.sv
module guarded_gate
   import gate_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int TAG_W      = 6,
   parameter int BLK_BYTES  = 64,
   parameter int PARK_DEPTH = 4,
   localparam int BLK_LOG2  = $clog2(BLK_BYTES),
   localparam int SZ_W      = (BLK_LOG2 < 1) ? 1 : $clog2(BLK_LOG2 + 1),
   localparam int BYTES_W   = BLK_LOG2 + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [SZ_W-1:0]    req_size,
   input  logic               req_spec,
   input  logic               req_guarded,
   input  logic               req_inhibit,
   input  logic               req_hit,
   input  logic               commit_valid,
   input  logic [TAG_W-1:0]   commit_tag,
   input  logic               flush,
   output logic               iss_valid,
   output logic [1:0]         iss_kind,
   output logic [TAG_W-1:0]   iss_tag,
   output logic [ADDR_W-1:0]  iss_addr,
   output logic [BYTES_W-1:0] iss_bytes,
   output logic               iss_exact,
   output logic               fault_valid,
   output logic [TAG_W-1:0]   fault_tag,
   output logic               stall,
   output logic               park_full,
   output logic               rel_valid,
   output logic [1:0]         rel_kind,
   output logic [TAG_W-1:0]   rel_tag,
   output logic [ADDR_W-1:0]  rel_addr,
   output logic [BYTES_W-1:0] rel_bytes,
   output logic               rel_exact
);
   localparam int ENT_W = TAG_W + 2 + 1 + SZ_W + ADDR_W;

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic [1:0]        kind;
      logic              inhibit;
      logic [SZ_W-1:0]   size;
      logic [ADDR_W-1:0] addr;
   } park_ent_t;

   decision_e  dec;
   park_ent_t  push_ent, head_ent;
   logic [ENT_W-1:0] head_raw;
   logic       q_empty, q_full, do_push, do_pop;

   gate_classify u_classify (
      .valid   (req_valid),
      .flush   (flush),
      .full    (q_full),
      .kind    (req_kind),
      .spec    (req_spec),
      .guarded (req_guarded),
      .hit     (req_hit),
      .dec     (dec)
   );

   assign push_ent = '{tag: req_tag, kind: req_kind, inhibit: req_inhibit,
                       size: req_size, addr: req_addr};
   assign do_push  = (dec == D_PARK);
   assign head_ent = park_ent_t'(head_raw);
   assign do_pop   = commit_valid && !flush && !q_empty && (head_ent.tag == commit_tag);

   gate_park_fifo #(
      .DEPTH (PARK_DEPTH),
      .W     (ENT_W)
   ) u_park (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (do_push),
      .push_data (push_ent),
      .pop       (do_pop),
      .head_data (head_raw),
      .empty     (q_empty),
      .full      (q_full)
   );

   gate_shape #(
      .ADDR_W   (ADDR_W),
      .BLK_LOG2 (BLK_LOG2),
      .SZ_W     (SZ_W),
      .BYTES_W  (BYTES_W)
   ) u_shape_iss (
      .addr    (req_addr),
      .size    (req_size),
      .inhibit (req_inhibit),
      .addr_o  (iss_addr),
      .bytes_o (iss_bytes),
      .exact_o (iss_exact)
   );

   gate_shape #(
      .ADDR_W   (ADDR_W),
      .BLK_LOG2 (BLK_LOG2),
      .SZ_W     (SZ_W),
      .BYTES_W  (BYTES_W)
   ) u_shape_rel (
      .addr    (head_ent.addr),
      .size    (head_ent.size),
      .inhibit (head_ent.inhibit),
      .addr_o  (rel_addr),
      .bytes_o (rel_bytes),
      .exact_o (rel_exact)
   );

   assign iss_valid   = (dec == D_PASS);
   assign iss_kind    = req_kind;
   assign iss_tag     = req_tag;
   assign fault_valid = (dec == D_FAULT);
   assign fault_tag   = req_tag;
   assign stall       = !q_empty;
   assign park_full   = q_full;
   assign rel_valid   = do_pop;
   assign rel_kind    = head_ent.kind;
   assign rel_tag     = head_ent.tag;
endmodule

// File: rtl/gate_chk.sv
module gate_chk #(
   parameter int ADDR_W     = 32,
   parameter int TAG_W      = 6,
   parameter int BLK_BYTES  = 64,
   parameter int PARK_DEPTH = 4,
   localparam int BLK_LOG2  = $clog2(BLK_BYTES),
   localparam int SZ_W      = (BLK_LOG2 < 1) ? 1 : $clog2(BLK_LOG2 + 1),
   localparam int BYTES_W   = BLK_LOG2 + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [1:0]         req_kind,
   input logic [TAG_W-1:0]   req_tag,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [SZ_W-1:0]    req_size,
   input logic               req_spec,
   input logic               req_guarded,
   input logic               req_inhibit,
   input logic               req_hit,
   input logic               commit_valid,
   input logic [TAG_W-1:0]   commit_tag,
   input logic               flush,
   input logic               iss_valid,
   input logic [1:0]         iss_kind,
   input logic [TAG_W-1:0]   iss_tag,
   input logic [ADDR_W-1:0]  iss_addr,
   input logic [BYTES_W-1:0] iss_bytes,
   input logic               iss_exact,
   input logic               fault_valid,
   input logic [TAG_W-1:0]   fault_tag,
   input logic               stall,
   input logic               park_full,
   input logic               rel_valid,
   input logic [1:0]         rel_kind,
   input logic [TAG_W-1:0]   rel_tag,
   input logic [ADDR_W-1:0]  rel_addr,
   input logic [BYTES_W-1:0] rel_bytes,
   input logic               rel_exact
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BLK_BYTES - 1);

   logic live, g_spec_ld_miss, g_spec_st;
   assign live           = req_valid && !flush;
   assign g_spec_ld_miss = live && req_guarded && req_spec && req_kind == 2'b00 && !req_hit;
   assign g_spec_st      = live && req_guarded && req_spec && req_kind[0];

   initial begin
      a_param_block_pow2: assert (BLK_BYTES >= 1 && (BLK_BYTES & (BLK_BYTES - 1)) == 0)
         else $error("BLK_BYTES must be a power of two");
      a_param_depth: assert (PARK_DEPTH >= 1) else $error("PARK_DEPTH must be at least 1");
      a_param_tag: assert (TAG_W >= 1 && ADDR_W > BLK_LOG2) else $error("bad widths");
   end

   // R1
   p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
      live && !req_guarded |-> iss_valid && iss_tag == req_tag && iss_kind == req_kind);
   // R2
   p_committed_guarded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_guarded && !req_spec && req_kind != 2'b10 |-> iss_valid);
   // R3
   p_spec_hit_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_guarded && req_spec && req_kind == 2'b00 && req_hit |-> iss_valid);
   // R4
   p_miss_parks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      g_spec_ld_miss && !park_full |-> !iss_valid ##1 stall);
   // R5
   p_spec_store_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      g_spec_st |-> !iss_valid);
   // R6
   p_fetch_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_guarded && req_kind == 2'b10 |-> fault_valid && !iss_valid && fault_tag == req_tag);
   p_fetch_never_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> rel_kind != 2'b10);
   // R7
   p_exact_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_exact |-> iss_bytes == (BYTES_W'(1) << req_size) && iss_addr == req_addr);
   p_block_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && !iss_exact |-> (iss_addr & LOW_MASK) == '0 && iss_bytes == BYTES_W'(BLK_BYTES));
   p_rel_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid && !rel_exact |-> (rel_addr & LOW_MASK) == '0 && rel_bytes == BYTES_W'(BLK_BYTES));
   // R8
   p_release_needs_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> commit_valid && !flush && rel_tag == commit_tag);
   // R9
   p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !stall);
   p_flush_silences_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !iss_valid && !fault_valid && !rel_valid);
   // R10
   p_release_from_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> stall);
   // R11
   p_reset_clears_r11: assert property (@(posedge clk)
      !rst_n |=> !stall && !park_full);
   // R12
   p_full_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      park_full && !rel_valid && !flush |=> park_full);
   p_full_implies_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      park_full |-> stall);
endmodule

bind guarded_gate gate_chk #(
   .ADDR_W     (ADDR_W),
   .TAG_W      (TAG_W),
   .BLK_BYTES  (BLK_BYTES),
   .PARK_DEPTH (PARK_DEPTH)
) u_gate_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_kind     (req_kind),
   .req_tag      (req_tag),
   .req_addr     (req_addr),
   .req_size     (req_size),
   .req_spec     (req_spec),
   .req_guarded  (req_guarded),
   .req_inhibit  (req_inhibit),
   .req_hit      (req_hit),
   .commit_valid (commit_valid),
   .commit_tag   (commit_tag),
   .flush        (flush),
   .iss_valid    (iss_valid),
   .iss_kind     (iss_kind),
   .iss_tag      (iss_tag),
   .iss_addr     (iss_addr),
   .iss_bytes    (iss_bytes),
   .iss_exact    (iss_exact),
   .fault_valid  (fault_valid),
   .fault_tag    (fault_tag),
   .stall        (stall),
   .park_full    (park_full),
   .rel_valid    (rel_valid),
   .rel_kind     (rel_kind),
   .rel_tag      (rel_tag),
   .rel_addr     (rel_addr),
   .rel_bytes    (rel_bytes),
   .rel_exact    (rel_exact)
);

// File: tb/guarded_gate_tb.sv
module guarded_gate_tb;
   localparam int AW = 32, TW = 6, BLK = 64, DEP = 4, SZW = 3, BW = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_spec = 0, req_guarded = 0, req_inhibit = 0, req_hit = 0;
   logic [1:0] req_kind = 0;
   logic [TW-1:0] req_tag = 0, commit_tag = 0;
   logic [AW-1:0] req_addr = 0;
   logic [SZW-1:0] req_size = 0;
   logic commit_valid = 0, flush = 0;
   logic iss_valid, iss_exact, fault_valid, stall, park_full, rel_valid, rel_exact;
   logic [1:0] iss_kind, rel_kind;
   logic [TW-1:0] iss_tag, fault_tag, rel_tag;
   logic [AW-1:0] iss_addr, rel_addr;
   logic [BW-1:0] iss_bytes, rel_bytes;

   int checks = 0, failures = 0, cycles = 0;
   string cur_r = "R1";

   typedef struct {
      int tag; int kind; bit inh; int size; longint unsigned addr;
   } ent_t;
   ent_t q[$];

   always #10 clk = ~clk;

   guarded_gate #(.ADDR_W(AW), .TAG_W(TW), .BLK_BYTES(BLK), .PARK_DEPTH(DEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_tag(req_tag),
      .req_addr(req_addr), .req_size(req_size), .req_spec(req_spec), .req_guarded(req_guarded),
      .req_inhibit(req_inhibit), .req_hit(req_hit), .commit_valid(commit_valid),
      .commit_tag(commit_tag), .flush(flush), .iss_valid(iss_valid), .iss_kind(iss_kind),
      .iss_tag(iss_tag), .iss_addr(iss_addr), .iss_bytes(iss_bytes), .iss_exact(iss_exact),
      .fault_valid(fault_valid), .fault_tag(fault_tag), .stall(stall), .park_full(park_full),
      .rel_valid(rel_valid), .rel_kind(rel_kind), .rel_tag(rel_tag), .rel_addr(rel_addr),
      .rel_bytes(rel_bytes), .rel_exact(rel_exact));

   task automatic chk(string r, string what, longint unsigned act, longint unsigned exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", r, what, act, exp, cycles);
      end
   endtask

   function automatic longint unsigned shp_addr(bit inh, longint unsigned a);
      return inh ? a : (a & ~longint'(BLK - 1));
   endfunction
   function automatic int shp_bytes(bit inh, int sz);
      return inh ? (1 << sz) : BLK;
   endfunction

   // One clock: compare at negedge against the reference, update the model, advance.
   task automatic step();
      bit v, full, e_fault, e_pass, e_park, e_rel;
      @(negedge clk);
      if (!rst_n) q.delete();
      v       = req_valid && !flush && rst_n;
      full    = (q.size() == DEP);
      e_fault = v && req_guarded && req_kind == 2'b10;
      e_pass  = v && !e_fault && (!req_guarded || !req_spec || (req_kind == 2'b00 && req_hit));
      e_park  = v && !e_fault && !e_pass && !full;
      e_rel   = commit_valid && !flush && rst_n && q.size() > 0 && q[0].tag == int'(commit_tag);
      if (rst_n) begin
         chk(cur_r, "iss_valid", iss_valid, e_pass);
         if (e_pass) begin
            chk(cur_r, "iss_tag", iss_tag, req_tag);
            chk(cur_r, "iss_kind", iss_kind, req_kind);
            chk("R7", "iss_addr", iss_addr, shp_addr(req_inhibit, req_addr));
            chk("R7", "iss_bytes", iss_bytes, shp_bytes(req_inhibit, int'(req_size)));
            chk("R7", "iss_exact", iss_exact, req_inhibit);
         end
         chk("R6", "fault_valid", fault_valid, e_fault);
         if (e_fault) chk("R6", "fault_tag", fault_tag, req_tag);
         chk("R8", "rel_valid", rel_valid, e_rel);
         if (e_rel) begin
            chk("R8", "rel_tag", rel_tag, q[0].tag);
            chk("R8", "rel_kind", rel_kind, q[0].kind);
            chk("R7", "rel_addr", rel_addr, shp_addr(q[0].inh, q[0].addr));
            chk("R7", "rel_bytes", rel_bytes, shp_bytes(q[0].inh, q[0].size));
            chk("R7", "rel_exact", rel_exact, q[0].inh);
         end
      end
      chk(rst_n ? "R10" : "R11", "stall", stall, q.size() != 0);
      chk(rst_n ? "R12" : "R11", "park_full", park_full, full);
      if (flush) q.delete();
      else if (rst_n) begin
         if (e_rel) void'(q.pop_front());
         if (e_park) q.push_back('{int'(req_tag), int'(req_kind), req_inhibit, int'(req_size), req_addr});
      end
      @(posedge clk);
      #1;
      cycles++;
      req_valid = 0; commit_valid = 0; flush = 0;
   endtask

   task automatic req(string r, int kind, int tag, longint unsigned addr, int sz,
                      bit spec, bit g, bit inh, bit hit);
      cur_r = r; req_valid = 1; req_kind = 2'(kind); req_tag = TW'(tag); req_addr = AW'(addr);
      req_size = SZW'(sz); req_spec = spec; req_guarded = g; req_inhibit = inh; req_hit = hit;
   endtask

   task automatic commit(int tag);
      commit_valid = 1; commit_tag = TW'(tag);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R11: reset state
      rst_n = 0;
      step(); step();
      rst_n = 1;
      step();
      // R1: non-guarded, each kind, both attribute settings (R7)
      req("R1", 0, 1, 32'h1234_5677, 2, 1, 0, 0, 0); step();
      req("R1", 1, 2, 32'h0000_10F3, 0, 1, 0, 1, 0); step();
      req("R1", 2, 3, 32'h8000_0044, 2, 1, 0, 0, 0); step();
      req("R1", 3, 4, 32'h8000_0047, 3, 0, 0, 1, 1); step();
      // R2: guarded, committed
      req("R2", 0, 5, 32'hFFFF_FFC1, 1, 0, 1, 1, 0); step();
      req("R2", 1, 6, 32'h0000_0ABC, 3, 0, 1, 0, 0); step();
      // R3: guarded speculative load hit
      req("R3", 0, 7, 32'h0000_2222, 2, 1, 1, 0, 1); step();
      req("R3", 0, 8, 32'h0000_2223, 0, 1, 1, 1, 1); step();
      // R6: guarded fetch, spec and not
      req("R6", 2, 9, 32'h0000_3000, 2, 1, 1, 0, 1); step();
      req("R6", 2, 10, 32'h0000_3004, 2, 0, 1, 1, 0); step();
      // R4 / R5: parking
      req("R4", 0, 11, 32'h0000_4011, 2, 1, 1, 1, 0); step();
      req("R5", 1, 12, 32'h0000_5013, 1, 1, 1, 0, 1); step();
      // R8: commit naming younger tag releases nothing
      commit(12); step();
      commit(11); step();
      // R8: release and park in the same cycle
      req("R5", 3, 13, 32'h0000_6666, 3, 1, 1, 1, 1); commit(12); step();
      commit(13); step();
      step();
      // R12: fill past depth
      req("R4", 0, 20, 32'h100, 0, 1, 1, 0, 0); step();
      req("R5", 1, 21, 32'h200, 1, 1, 1, 1, 0); step();
      req("R4", 0, 22, 32'h300, 2, 1, 1, 1, 0); step();
      req("R5", 1, 23, 32'h400, 3, 1, 1, 0, 1); step();
      req("R12", 0, 24, 32'h500, 0, 1, 1, 0, 0); step();
      req("R12", 1, 25, 32'h600, 0, 1, 1, 0, 0); commit(24); step();
      // R12: release while full, then park succeeds next cycle
      commit(20); step();
      req("R4", 0, 26, 32'h700, 1, 1, 1, 1, 0); step();
      // R9: flush with a matching commit and an incoming request
      req("R9", 0, 27, 32'h800, 0, 1, 0, 0, 0); commit(21); flush = 1; step();
      commit(21); step();
      req("R9", 1, 28, 32'h900, 2, 1, 1, 1, 0); step();
      req("R9", 2, 29, 32'hA00, 2, 1, 1, 1, 0); flush = 1; step();
      // R11: reset in the middle with parked entries
      req("R4", 0, 30, 32'hB00, 0, 1, 1, 0, 0); step();
      rst_n = 0; step();
      rst_n = 1; step();
      commit(28); step();
      // Sweep sizes on the exact path (R7)
      for (int s = 0; s <= 6; s++) begin
         req("R2", s % 2, 40 + s, 32'hC0DE_0000 + 32'(s * 9), s, 0, 1, 1, 0); step();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule